// File: doc/BRIEF.md
# FIFO Occupancy and Misuse Monitor

This block watches the write and read events of a clock-crossing FIFO. Both events are presented in a single monitoring clock. From them it keeps a shadow count of how many entries the FIFO holds. It raises sticky flags when the traffic breaks the transfer rules: writing into a full FIFO, reading from an empty one, or writing and reading in the same monitoring cycle. It also gathers coverage figures: the total writes seen, the total reads seen, and the highest occupancy reached since reset.

The monitor is synthesizable, so it can sit in simulation regressions, in emulation, or on silicon as a debug observer. The FIFO capacity is a parameter. It must be a power of two from 4 to 256, and any other value stops elaboration. The storage array and the pointer synchronizers belong to the observed FIFO and are not part of this block. Every output is registered and reflects the events sampled at the most recent rising clock edge.

Top module: `fifo_guard_monitor`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the shadow level, the peak, both event counters and all three flags to zero at that edge.
- R2: A cycle with `wr_evt` high, `rd_evt` low and level below DEPTH raises `level_o` by one at that edge.
- R3: A cycle with `wr_evt` high while `level_o` equals DEPTH sets `overflow_o`, and the level does not increase.
- R4: A cycle with `rd_evt` high, `wr_evt` low and level above zero lowers `level_o` by one.
- R5: A cycle with `rd_evt` high while `level_o` is zero sets `underflow_o`, and the level does not decrease.
- R6: A cycle with both `wr_evt` and `rd_evt` high sets `collide_o` and leaves `level_o` unchanged.
- R7: `wr_count_o` increments by one, wrapping at its width, for every cycle in which `wr_evt` is high, legal or not.
- R8: `rd_count_o` increments by one, wrapping at its width, for every cycle in which `rd_evt` is high, legal or not.
- R9: `peak_o` equals the largest value `level_o` has taken since reset, and it is updated at the same edge as the level.
- R10: Once set, `overflow_o`, `underflow_o` and `collide_o` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitoring clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_evt | input | 1 | FIFO write event, one per cycle high |
| rd_evt | input | 1 | FIFO read event, one per cycle high |
| overflow_o | output | 1 | Sticky: write seen while full |
| underflow_o | output | 1 | Sticky: read seen while empty |
| collide_o | output | 1 | Sticky: write and read in the same cycle |
| wr_count_o | output | CNT_W | Total write events since reset |
| rd_count_o | output | CNT_W | Total read events since reset |
| level_o | output | $clog2(DEPTH)+1 | Current shadow occupancy |
| peak_o | output | $clog2(DEPTH)+1 | Highest occupancy since reset |

## Verification
The bench builds the monitor with DEPTH of 4 and a 16-bit counter width. The small depth lets a few writes reach full and a few reads reach empty, so both boundaries are hit many times during a run of pseudo-random traffic, and the peak saturates at DEPTH. A reset partway through the run checks that the sticky flags and the coverage figures clear and then build up again from zero.

// File: rtl/fgm_pkg.sv
// Shared definitions for the FIFO guard monitor.
// Assumes write and read events are already in the monitoring clock domain.
package fgm_pkg;

    // Kind of traffic seen in one monitoring cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_BOTH = 2'b11
    } fgm_op_e;

    // Folds the two event strobes into one traffic kind.
    function automatic fgm_op_e classify(input logic wr, input logic rd);
        return fgm_op_e'({rd, wr});
    endfunction

    // True when v is a power of two inside the supported range.
    function automatic bit depth_ok(input int v);
        return (v >= 4) && (v <= 256) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fgm_level_track.sv
// Shadow occupancy tracker plus sticky misuse flags.
// What it does: keeps a level that moves only on a legal lone write or a
// lone read; an illegal operation or a collision leaves the level as it is.
// Assumes: DEPTH is valid (checked at the top), LW can hold DEPTH.
module fgm_level_track
    import fgm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic          ovf,
    output logic          udf,
    output logic          col
);

    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    fgm_op_e op;
    logic    full_hit;
    logic    empty_hit;

    // Next level and the misuse conditions for this cycle.
    always_comb begin
        op        = classify(wr, rd);
        full_hit  = wr && (level == FULL);
        empty_hit = rd && (level == '0);
        level_nxt = level;
        unique case (op)
            OP_WR:   if (!full_hit)  level_nxt = level + LW'(1);
            OP_RD:   if (!empty_hit) level_nxt = level - LW'(1);
            default: level_nxt = level;
        endcase
    end

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_nxt;
    end

    // Sticky misuse flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
            col <= 1'b0;
        end else begin
            ovf <= ovf | full_hit;
            udf <= udf | empty_hit;
            col <= col | (wr & rd);
        end
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);
    p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && level < FULL) |=> level == $past(level) + LW'(1));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && level == FULL) |=> (ovf && level <= FULL));
    p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && level != '0) |=> level == $past(level) - LW'(1));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && level == '0) |=> (udf && $stable(level)));
    p_collide_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd) |=> (col && $stable(level)));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        udf |=> udf);
    p_col_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        col |=> col);

endmodule

// File: rtl/fgm_event_count.sv
// Wrapping event counter used as a coverage figure.
// What it does: adds one on every cycle its strobe is high.
// Assumes: wrap-around at CW bits is acceptable to the reader.
module fgm_event_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [CW-1:0] count
);

    // Counts strobe cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (hit) count <= count + CW'(1);
    end

    // Covers R7 (write channel) and R8 (read channel).
    p_count_step_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> count == $past(count) + CW'(1));
    p_count_hold_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(count));

endmodule

// File: rtl/fgm_peak_hold.sv
// High-water mark of the shadow occupancy.
// What it does: takes the next level and keeps the largest seen, so the peak
// moves at the same edge as the level itself.
// Assumes: level_cur is the registered form of level_nxt.
module fgm_peak_hold #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level_nxt,
    input  logic [LW-1:0] level_cur,
    output logic [LW-1:0] peak
);

    // Keeps the running maximum of the level.
    always_ff @(posedge clk) begin
        if (!rst_n)                 peak <= '0;
        else if (level_nxt > peak)  peak <= level_nxt;
    end

    p_peak_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        peak >= level_cur);
    p_peak_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> peak >= $past(peak));

endmodule

// File: rtl/fifo_guard_monitor.sv
// FIFO guard monitor top.
// What it does: ties the level tracker, the two event counters and the peak
// holder together and exposes flags and coverage figures.
// Assumes: write/read strobes are in clk's domain; DEPTH is a power of two
// from 4 to 256.
module fifo_guard_monitor
    import fgm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_evt,
    input  logic             rd_evt,
    output logic             overflow_o,
    output logic             underflow_o,
    output logic             collide_o,
    output logic [CNT_W-1:0] wr_count_o,
    output logic [CNT_W-1:0] rd_count_o,
    output logic [LW-1:0]    level_o,
    output logic [LW-1:0]    peak_o
);

    localparam int NCH = 2;

    // Stops elaboration on an unsupported depth.
    initial begin
        a_depth_legal: assert (depth_ok(DEPTH))
            else $fatal(1, "fifo_guard_monitor: DEPTH must be a power of two in 4..256");
    end

    logic [LW-1:0]    level_nxt;
    logic [NCH-1:0]   strobe;
    logic [CNT_W-1:0] tally [NCH];

    assign strobe = {rd_evt, wr_evt};

    fgm_level_track #(.DEPTH(DEPTH), .LW(LW)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_evt),
        .rd        (rd_evt),
        .level     (level_o),
        .level_nxt (level_nxt),
        .ovf       (overflow_o),
        .udf       (underflow_o),
        .col       (collide_o)
    );

    // One counter per event channel: 0 for writes (R7), 1 for reads (R8).
    for (genvar g = 0; g < NCH; g++) begin : g_cnt
        fgm_event_count #(.CW(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (strobe[g]),
            .count (tally[g])
        );
    end

    assign wr_count_o = tally[0];
    assign rd_count_o = tally[1];

    fgm_peak_hold #(.LW(LW)) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_nxt (level_nxt),
        .level_cur (level_o),
        .peak      (peak_o)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0 && peak_o == '0 && wr_count_o == '0 &&
                    rd_count_o == '0 && !overflow_o && !underflow_o && !collide_o));

endmodule

// File: tb/fifo_guard_monitor_tb.sv
`timescale 1ns/1ps
module fifo_guard_monitor_tb;

    localparam int DEPTH = 4;
    localparam int CNT_W = 16;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_evt = 1'b0;
    logic             rd_evt = 1'b0;
    logic             overflow_o, underflow_o, collide_o;
    logic [CNT_W-1:0] wr_count_o, rd_count_o;
    logic [LW-1:0]    level_o, peak_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference state.
    int  m_lvl, m_peak, m_wc, m_rc;
    bit  m_ovf, m_udf, m_col;

    always #2 clk = ~clk;

    fifo_guard_monitor #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
        .overflow_o(overflow_o), .underflow_o(underflow_o), .collide_o(collide_o),
        .wr_count_o(wr_count_o), .rd_count_o(rd_count_o),
        .level_o(level_o), .peak_o(peak_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_lvl = 0; m_peak = 0; m_wc = 0; m_rc = 0;
        m_ovf = 0; m_udf = 0; m_col = 0;
    endtask

    task automatic model_step(input bit w, input bit r);
        if (w && m_lvl == DEPTH) m_ovf = 1;
        if (r && m_lvl == 0)     m_udf = 1;
        if (w && r)              m_col = 1;
        if (w) m_wc = (m_wc + 1) % (1 << CNT_W);
        if (r) m_rc = (m_rc + 1) % (1 << CNT_W);
        if (w && !r && m_lvl < DEPTH)  m_lvl++;
        else if (r && !w && m_lvl > 0) m_lvl--;
        if (m_lvl > m_peak) m_peak = m_lvl;
    endtask

    task automatic compare_all();
        chk("R2 R4 R5 R6 level", int'(level_o), m_lvl);
        chk("R3 R10 overflow", int'(overflow_o), int'(m_ovf));
        chk("R5 R10 underflow", int'(underflow_o), int'(m_udf));
        chk("R6 R10 collide", int'(collide_o), int'(m_col));
        chk("R7 wr_count", int'(wr_count_o), m_wc);
        chk("R8 rd_count", int'(rd_count_o), m_rc);
        chk("R9 peak", int'(peak_o), m_peak);
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next fall.
    task automatic cyc(input bit w, input bit r);
        wr_evt = w; rd_evt = r;
        @(posedge clk);
        model_step(w, r);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_evt = 1'b0; rd_evt = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all outputs cleared
        chk("R1 level", int'(level_o), 0);
        chk("R1 peak", int'(peak_o), 0);
        chk("R1 counts", int'(wr_count_o) + int'(rd_count_o), 0);
        chk("R1 flags", int'({overflow_o, underflow_o, collide_o}), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        model_clear();
        @(negedge clk);
        do_reset();

        // R2: fill to DEPTH
        for (int i = 0; i < DEPTH; i++) cyc(1, 0);
        chk("R2 full", int'(level_o), DEPTH);
        // R3: write into full
        cyc(1, 0);
        chk("R3 overflow set", int'(overflow_o), 1);
        // R4: two reads
        cyc(0, 1); cyc(0, 1);
        chk("R4 level", int'(level_o), DEPTH - 2);
        // R6: collision holds level
        cyc(1, 1);
        chk("R6 collide set", int'(collide_o), 1);
        // drain then R5 read on empty
        cyc(0, 1); cyc(0, 1);
        cyc(0, 1);
        chk("R5 underflow set", int'(underflow_o), 1);
        chk("R5 level zero", int'(level_o), 0);
        // R10: idle cycles keep flags
        for (int i = 0; i < 5; i++) cyc(0, 0);
        chk("R10 flags held", int'({overflow_o, underflow_o, collide_o}), 7);
        // R9: peak stays at DEPTH while level is low
        chk("R9 peak held", int'(peak_o), DEPTH);

        // R1: reset in the middle, then build up again
        cyc(1, 0); cyc(1, 0);
        @(negedge clk);
        do_reset();
        cyc(1, 0);
        chk("R9 peak after reset", int'(peak_o), 1);

        // Pseudo-random traffic across both boundaries
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0] & ~lfsr[3], lfsr[1] & ~lfsr[2]);
        end
        for (int i = 0; i < 50; i++) cyc(1, i[0] & i[1] & i[2]);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule